// File: doc/BRIEF.md
# Scatter-Gather Chain Walker

This block walks the scatter-gather list that belongs to one storage command and hands a DMA data mover one data segment at a time. Each segment is an address, a byte length and a discard marker. The walker reads 16-byte list entries through a memory read port that has a request/response handshake. It follows link entries into further tables and stops at the entry marked last. It reports bad table alignment and list exhaustion as numeric error codes.

Software, or a command engine, gives the walker the base address of a command block and says whether the block is a plain command or a packet command. Packet commands carry a command descriptor ahead of the list. The caller also gives the transfer direction. The walker then fetches entries in order. The mover acknowledges each segment when it has consumed it, and at the same time it says whether the device still has data for the command. The walk ends with a one-cycle completion pulse and an error code, where zero means success.

Top module: `sgl_walker`

## Requirements
- R1: An entry at address E is fetched as two 64-bit little-endian read beats, the first at E and the second at E+8, with one request outstanding at a time.
  - The first beat is the buffer address.
  - Bits [31:0] of the second beat are the byte count.
  - Bits [63:32] of the second beat are the flags word.
  - A request that is not yet accepted keeps its address unchanged.
- R2: The first list table starts 32 bytes after `start_addr` when `pkt_mode`=0. It starts 48 bytes after `start_addr` when `pkt_mode`=1.
- R3: A data entry with a non-zero count produces exactly one segment carrying the entry's address and count, with `seg_discard`=0.
  - The segment is held stable until `seg_done`.
  - No read request is made while a segment is presented.
- R4: An entry whose flags bit 29 is set produces a segment with `seg_discard`=1 and `seg_addr`=0. The entry's address field is ignored.
- R5: An entry whose flags bit 30 is set is a link. It produces no segment, its count is ignored, and the next entry is fetched from its address.
- R6: A non-link entry with a zero count produces no segment, and the walk moves on to the next entry.
- R7: After an entry whose flags bit 31 is set, nothing more is fetched. A last entry that is also a link is not followed.
- R8: The list can run out while the device still has data. This happens when `seg_done` arrives with `dev_more`=1 on the last entry's segment, or when the last entry produces no segment. The walk then ends with error 7 if `dir_wr` was 1 at start, or error 8 if it was 0.
- R9: A table address whose low three bits are not zero ends the walk with error 16, and no read is issued from that address. This covers both the first table and a link target.
- R10: `seg_done` with `dev_more`=0 ends the walk with error 0, and no further entries are fetched.
- R11: `done` is a one-cycle pulse at the end of every walk. `err_code` keeps its value until the next accepted start, which clears it to 0.
- R12: A `start` pulse while a walk is in progress has no effect.
- R13: After reset, `req_valid`, `seg_valid` and `done` are 0 and `err_code` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a walk (accepted only when idle) |
| start_addr | input | 64 | Command block base address |
| pkt_mode | input | 1 | 1 = packet command block (descriptor before list) |
| dir_wr | input | 1 | 1 = write-direction command, 0 = read-direction |
| req_valid | output | 1 | Memory read request valid |
| req_addr | output | 64 | Memory read byte address (qword aligned) |
| req_ready | input | 1 | Memory read request accepted |
| rsp_valid | input | 1 | Read response valid |
| rsp_data | input | 64 | Read response data, little-endian |
| seg_valid | output | 1 | Segment presented to the mover |
| seg_addr | output | 64 | Segment buffer address (0 for discard) |
| seg_len | output | 32 | Segment byte length |
| seg_discard | output | 1 | Segment data is to be dropped |
| seg_done | input | 1 | Mover finished the current segment |
| dev_more | input | 1 | With seg_done: device still has data |
| done | output | 1 | One-cycle end-of-walk pulse |
| err_code | output | 6 | 0, 7, 8 or 16; held until next start |

## Verification
The assertions take the following for granted about the inputs:
- every read response answers exactly one accepted request, arriving one or more cycles later;
- `seg_done` is raised only while `seg_valid` is high;
- `start_addr`, `pkt_mode` and `dir_wr` are meaningful in the cycle `start` is high.

The stimulus keeps within these rules. The memory model answers each handshake on the next cycle and stalls `req_ready` on a fixed pattern. The mover model raises `seg_done` for a single cycle a few cycles after it sees a segment, and only then. Tables are built so that the only misaligned addresses are the ones a test means to reject.

// File: rtl/sgw_pkg.sv
package sgw_pkg;

    // Entry format, fixed by the list layout
    localparam int SGW_AW          = 64;
    localparam int SGW_LW          = 32;
    localparam int SGW_BEAT_W      = 64;
    localparam int SGW_BEAT_BYTES  = SGW_BEAT_W / 8;
    localparam int SGW_ENTRY_BYTES = 2 * SGW_BEAT_BYTES;
    localparam int SGW_ALIGN_BITS  = $clog2(SGW_BEAT_BYTES);

    // Flag bit positions inside the flags word
    localparam int SGW_F_LAST = 31;
    localparam int SGW_F_LINK = 30;
    localparam int SGW_F_DISC = 29;

    // Error codes
    localparam int SGW_ERR_NONE  = 0;
    localparam int SGW_ERR_UNDER = 7;
    localparam int SGW_ERR_OVER  = 8;
    localparam int SGW_ERR_ALIGN = 16;

    typedef struct packed {
        logic [SGW_AW-1:0] addr;
        logic [SGW_LW-1:0] len;
        logic [SGW_LW-1:0] flags;
    } sgw_entry_t;

    typedef enum logic [1:0] {
        K_DATA    = 2'd0,
        K_DISCARD = 2'd1,
        K_LINK    = 2'd2,
        K_SKIP    = 2'd3
    } sgw_kind_t;

endpackage

// File: rtl/sgw_fetch.sv
module sgw_fetch
    import sgw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [SGW_AW-1:0] go_addr,
    output logic              req_valid,
    output logic [SGW_AW-1:0] req_addr,
    input  logic              req_ready,
    input  logic              rsp_valid,
    input  logic [SGW_BEAT_W-1:0] rsp_data,
    output logic              ent_vld,
    output sgw_entry_t        ent
);

    typedef enum logic [2:0] {
        F_IDLE  = 3'd0,
        F_REQ0  = 3'd1,
        F_WAIT0 = 3'd2,
        F_REQ1  = 3'd3,
        F_WAIT1 = 3'd4
    } fst_t;

    typedef struct packed {
        fst_t              st;
        logic [SGW_AW-1:0] addr;
        logic [SGW_AW-1:0] buf_addr;
        sgw_entry_t        ent;
        logic              vld;
    } freg_t;

    freg_t fetch_q, fetch_d;

    always_comb begin
        fetch_d     = fetch_q;
        fetch_d.vld = 1'b0;
        unique case (fetch_q.st)
            F_IDLE: begin
                if (go) begin
                    fetch_d.addr = go_addr;
                    fetch_d.st   = F_REQ0;
                end
            end
            F_REQ0: begin
                if (req_ready) fetch_d.st = F_WAIT0;
            end
            F_WAIT0: begin
                if (rsp_valid) begin
                    fetch_d.buf_addr = rsp_data;
                    fetch_d.addr     = fetch_q.addr + SGW_AW'(SGW_BEAT_BYTES);
                    fetch_d.st       = F_REQ1;
                end
            end
            F_REQ1: begin
                if (req_ready) fetch_d.st = F_WAIT1;
            end
            F_WAIT1: begin
                if (rsp_valid) begin
                    fetch_d.ent.addr  = fetch_q.buf_addr;
                    fetch_d.ent.len   = rsp_data[SGW_LW-1:0];
                    fetch_d.ent.flags = rsp_data[SGW_BEAT_W-1:SGW_LW];
                    fetch_d.vld       = 1'b1;
                    fetch_d.st        = F_IDLE;
                end
            end
            default: fetch_d.st = F_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fetch_q <= '0;
        else        fetch_q <= fetch_d;
    end

    assign req_valid = (fetch_q.st == F_REQ0) || (fetch_q.st == F_REQ1);
    assign req_addr  = fetch_q.addr;
    assign ent_vld   = fetch_q.vld;
    assign ent       = fetch_q.ent;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_addr)); // R1
    AST_REQ_QWORD: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> req_addr[SGW_ALIGN_BITS-1:0] == '0); // R9
    AST_GO_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !req_valid && !ent_vld); // R1

endmodule

// File: rtl/sgw_classify.sv
module sgw_classify
    import sgw_pkg::*;
(
    input  sgw_entry_t ent,
    output sgw_kind_t  kind,
    output logic       is_last
);

    logic [SGW_LW-1:0] unused_flags;
    assign unused_flags = ent.flags;

    always_comb begin
        if (ent.flags[SGW_F_LINK])      kind = K_LINK;
        else if (ent.len == '0)         kind = K_SKIP;
        else if (ent.flags[SGW_F_DISC]) kind = K_DISCARD;
        else                            kind = K_DATA;
    end

    assign is_last = ent.flags[SGW_F_LAST];

endmodule

// File: rtl/sgw_ctrl.sv
module sgw_ctrl
    import sgw_pkg::*;
#(
    parameter int HDR_BYTES = 32,
    parameter int CDB_BYTES = 16,
    parameter int ERR_W     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [SGW_AW-1:0] start_addr,
    input  logic              pkt_mode,
    input  logic              dir_wr,
    input  logic              ent_vld,
    input  sgw_kind_t         ent_kind,
    input  logic              ent_last,
    input  logic [SGW_AW-1:0] ent_addr,
    input  logic [SGW_LW-1:0] ent_len,
    output logic              fetch_go,
    output logic [SGW_AW-1:0] fetch_addr,
    output logic              seg_valid,
    output logic [SGW_AW-1:0] seg_addr,
    output logic [SGW_LW-1:0] seg_len,
    output logic              seg_discard,
    input  logic              seg_done,
    input  logic              dev_more,
    output logic              done,
    output logic [ERR_W-1:0]  err_code
);

    localparam logic [SGW_AW-1:0] OFS_PLAIN  = SGW_AW'(HDR_BYTES);
    localparam logic [SGW_AW-1:0] OFS_PACKET = SGW_AW'(HDR_BYTES + CDB_BYTES);
    localparam logic [SGW_AW-1:0] ENT_STEP   = SGW_AW'(SGW_ENTRY_BYTES);
    localparam logic [ERR_W-1:0]  E_NONE     = ERR_W'(SGW_ERR_NONE);
    localparam logic [ERR_W-1:0]  E_UNDER    = ERR_W'(SGW_ERR_UNDER);
    localparam logic [ERR_W-1:0]  E_OVER     = ERR_W'(SGW_ERR_OVER);
    localparam logic [ERR_W-1:0]  E_ALIGN    = ERR_W'(SGW_ERR_ALIGN);

    typedef enum logic [1:0] {
        C_IDLE  = 2'd0,
        C_FETCH = 2'd1,
        C_SEG   = 2'd2
    } cst_t;

    typedef struct packed {
        cst_t              st;
        logic [SGW_AW-1:0] ent_ptr;
        logic              last;
        logic              wr;
        logic              go;
        logic [SGW_AW-1:0] go_addr;
        logic              seg_v;
        logic [SGW_AW-1:0] seg_a;
        logic [SGW_LW-1:0] seg_l;
        logic              seg_d;
        logic              done;
        logic [ERR_W-1:0]  err;
    } creg_t;

    creg_t ctl_q, ctl_d;

    function automatic logic misaligned(input logic [SGW_AW-1:0] a);
        return a[SGW_ALIGN_BITS-1:0] != '0;
    endfunction

    always_comb begin
        logic [SGW_AW-1:0] tab;
        logic [ERR_W-1:0]  exhaust;
        tab          = '0;
        exhaust      = ctl_q.wr ? E_UNDER : E_OVER;
        ctl_d        = ctl_q;
        ctl_d.go     = 1'b0;
        ctl_d.done   = 1'b0;
        unique case (ctl_q.st)
            C_IDLE: begin
                if (start) begin
                    tab       = start_addr + (pkt_mode ? OFS_PACKET : OFS_PLAIN);
                    ctl_d.err = E_NONE;
                    ctl_d.wr  = dir_wr;
                    if (misaligned(tab)) begin
                        ctl_d.err  = E_ALIGN;
                        ctl_d.done = 1'b1;
                    end else begin
                        ctl_d.ent_ptr = tab;
                        ctl_d.go      = 1'b1;
                        ctl_d.go_addr = tab;
                        ctl_d.st      = C_FETCH;
                    end
                end
            end
            C_FETCH: begin
                if (ent_vld) begin
                    if ((ent_kind == K_LINK || ent_kind == K_SKIP) && ent_last) begin
                        // chain ends with the device still expecting data
                        ctl_d.err  = exhaust;
                        ctl_d.done = 1'b1;
                        ctl_d.st   = C_IDLE;
                    end else if (ent_kind == K_LINK) begin
                        if (misaligned(ent_addr)) begin
                            ctl_d.err  = E_ALIGN;
                            ctl_d.done = 1'b1;
                            ctl_d.st   = C_IDLE;
                        end else begin
                            ctl_d.ent_ptr = ent_addr;
                            ctl_d.go      = 1'b1;
                            ctl_d.go_addr = ent_addr;
                        end
                    end else if (ent_kind == K_SKIP) begin
                        ctl_d.ent_ptr = ctl_q.ent_ptr + ENT_STEP;
                        ctl_d.go      = 1'b1;
                        ctl_d.go_addr = ctl_q.ent_ptr + ENT_STEP;
                    end else begin
                        ctl_d.seg_v = 1'b1;
                        ctl_d.seg_a = (ent_kind == K_DISCARD) ? '0 : ent_addr;
                        ctl_d.seg_l = ent_len;
                        ctl_d.seg_d = (ent_kind == K_DISCARD);
                        ctl_d.last  = ent_last;
                        ctl_d.st    = C_SEG;
                    end
                end
            end
            C_SEG: begin
                if (seg_done) begin
                    ctl_d.seg_v = 1'b0;
                    if (!dev_more) begin
                        ctl_d.done = 1'b1;
                        ctl_d.st   = C_IDLE;
                    end else if (ctl_q.last) begin
                        ctl_d.err  = exhaust;
                        ctl_d.done = 1'b1;
                        ctl_d.st   = C_IDLE;
                    end else begin
                        ctl_d.ent_ptr = ctl_q.ent_ptr + ENT_STEP;
                        ctl_d.go      = 1'b1;
                        ctl_d.go_addr = ctl_q.ent_ptr + ENT_STEP;
                        ctl_d.st      = C_FETCH;
                    end
                end
            end
            default: ctl_d.st = C_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign fetch_go    = ctl_q.go;
    assign fetch_addr  = ctl_q.go_addr;
    assign seg_valid   = ctl_q.seg_v;
    assign seg_addr    = ctl_q.seg_a;
    assign seg_len     = ctl_q.seg_l;
    assign seg_discard = ctl_q.seg_d;
    assign done        = ctl_q.done;
    assign err_code    = ctl_q.err;

    AST_SEG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid && !seg_done |=> seg_valid && $stable(seg_addr)
                                   && $stable(seg_len) && $stable(seg_discard)); // R3
    AST_DISCARD_NULL: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid && seg_discard |-> seg_addr == '0); // R4
    AST_SEG_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid |-> seg_len != '0); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11
    AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(err_code) |-> done || $past(start)); // R11
    AST_ERR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        err_code == E_NONE || err_code == E_UNDER
        || err_code == E_OVER || err_code == E_ALIGN); // R8

endmodule

// File: rtl/sgl_walker.sv
module sgl_walker
    import sgw_pkg::*;
#(
    parameter int HDR_BYTES = 32,
    parameter int CDB_BYTES = 16,
    parameter int ERR_W     = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [SGW_AW-1:0]     start_addr,
    input  logic                  pkt_mode,
    input  logic                  dir_wr,
    output logic                  req_valid,
    output logic [SGW_AW-1:0]     req_addr,
    input  logic                  req_ready,
    input  logic                  rsp_valid,
    input  logic [SGW_BEAT_W-1:0] rsp_data,
    output logic                  seg_valid,
    output logic [SGW_AW-1:0]     seg_addr,
    output logic [SGW_LW-1:0]     seg_len,
    output logic                  seg_discard,
    input  logic                  seg_done,
    input  logic                  dev_more,
    output logic                  done,
    output logic [ERR_W-1:0]      err_code
);

    logic              fetch_go;
    logic [SGW_AW-1:0] fetch_addr;
    logic              ent_vld;
    sgw_entry_t        ent;
    sgw_kind_t         ent_kind;
    logic              ent_last;

    sgw_fetch u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (fetch_go),
        .go_addr   (fetch_addr),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_ready (req_ready),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data),
        .ent_vld   (ent_vld),
        .ent       (ent)
    );

    sgw_classify u_classify (
        .ent     (ent),
        .kind    (ent_kind),
        .is_last (ent_last)
    );

    sgw_ctrl #(
        .HDR_BYTES (HDR_BYTES),
        .CDB_BYTES (CDB_BYTES),
        .ERR_W     (ERR_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .start_addr  (start_addr),
        .pkt_mode    (pkt_mode),
        .dir_wr      (dir_wr),
        .ent_vld     (ent_vld),
        .ent_kind    (ent_kind),
        .ent_last    (ent_last),
        .ent_addr    (ent.addr),
        .ent_len     (ent.len),
        .fetch_go    (fetch_go),
        .fetch_addr  (fetch_addr),
        .seg_valid   (seg_valid),
        .seg_addr    (seg_addr),
        .seg_len     (seg_len),
        .seg_discard (seg_discard),
        .seg_done    (seg_done),
        .dev_more    (dev_more),
        .done        (done),
        .err_code    (err_code)
    );

    AST_QUIET_BUS_IN_SEG: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid |-> !req_valid); // R3
    AST_NO_FETCH_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !req_valid); // R7

endmodule

// File: tb/sgl_walker_tb_top.sv
module sgl_walker_tb_top;

    localparam logic [31:0] F_LAST = 32'h8000_0000;
    localparam logic [31:0] F_LINK = 32'h4000_0000;
    localparam logic [31:0] F_DISC = 32'h2000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] start_addr = '0;
    logic        pkt_mode = 1'b0;
    logic        dir_wr = 1'b0;
    logic        req_valid;
    logic [63:0] req_addr;
    logic        req_ready;
    logic        rsp_valid = 1'b0;
    logic [63:0] rsp_data = '0;
    logic        seg_valid;
    logic [63:0] seg_addr;
    logic [31:0] seg_len;
    logic        seg_discard;
    logic        seg_done = 1'b0;
    logic        dev_more = 1'b0;
    logic        done;
    logic [5:0]  err_code;

    sgl_walker dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .pkt_mode(pkt_mode), .dir_wr(dir_wr), .req_valid(req_valid),
        .req_addr(req_addr), .req_ready(req_ready), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .seg_valid(seg_valid), .seg_addr(seg_addr),
        .seg_len(seg_len), .seg_discard(seg_discard), .seg_done(seg_done),
        .dev_more(dev_more), .done(done), .err_code(err_code)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int fails  = 0;

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // memory model: one-cycle response, fixed stall pattern
    logic [63:0] mem [logic [63:0]];
    logic [63:0] req_log [$];
    int unsigned cyc = 0;
    assign req_ready = (cyc % 3) != 1;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        rsp_valid <= 1'b0;
        if (req_valid && req_ready) begin
            rsp_valid <= 1'b1;
            rsp_data  <= mem.exists(req_addr) ? mem[req_addr] : 64'h0;
            req_log.push_back(req_addr);
        end
    end

    task automatic put_ent(input logic [63:0] a, input logic [63:0] b,
                           input logic [31:0] len, input logic [31:0] fl);
        mem[a]     = b;
        mem[a + 8] = {fl, len};
    endtask

    // scoreboard of expected segments
    typedef struct {
        logic [63:0] a;
        logic [31:0] l;
        logic        d;
        logic        m;
    } exp_t;
    exp_t exp_q [$];

    task automatic exp_seg(input logic [63:0] a, input logic [31:0] l,
                           input logic d, input logic m);
        exp_t it;
        it.a = a; it.l = l; it.d = d; it.m = m;
        exp_q.push_back(it);
    endtask

    // mover model / monitor
    initial begin
        forever begin
            @(negedge clk);
            if (seg_valid) begin
                logic more;
                if (exp_q.size() == 0) begin
                    chk("R3", "unexpected segment", seg_addr, 64'hFFFF_FFFF_FFFF_FFFF);
                    more = 1'b0;
                end else begin
                    exp_t it;
                    it = exp_q.pop_front();
                    chk("R3", "segment address", seg_addr, it.a);
                    chk("R3", "segment length", {32'h0, seg_len}, {32'h0, it.l});
                    chk("R4", "segment discard flag", {63'h0, seg_discard}, {63'h0, it.d});
                    more = it.m;
                end
                repeat (2) @(negedge clk);
                seg_done = 1'b1;
                dev_more = more;
                @(negedge clk);
                seg_done = 1'b0;
                dev_more = 1'b0;
            end
        end
    end

    task automatic run_walk(input string tag, input logic [63:0] base,
                            input logic pkt, input logic wr, input int exp_err,
                            input int exp_reqs, input logic [63:0] exp_first,
                            input bit chk_clear, input bit poke, output int n0);
        bit got;
        int t;
        n0 = req_log.size();
        @(negedge clk);
        start = 1'b1; start_addr = base; pkt_mode = pkt; dir_wr = wr;
        @(negedge clk);
        start = 1'b0;
        if (chk_clear) chk("R11", "error cleared by start", {58'h0, err_code}, 64'h0);
        got = done;
        t = 0;
        while (!got && t < 5000) begin
            @(negedge clk);
            t++;
            if (poke && t == 3) begin
                start = 1'b1; start_addr = 64'h8004; pkt_mode = 1'b0; dir_wr = 1'b1;
            end else begin
                start = 1'b0;
            end
            got = done;
        end
        start = 1'b0;
        if (!got) chk(tag, "walk timeout", 64'h0, 64'h1);
        chk(tag, "error code", {58'h0, err_code}, 64'(exp_err));
        chk(tag, "read request count", 64'(req_log.size() - n0), 64'(exp_reqs));
        if (exp_reqs > 0 && req_log.size() > n0)
            chk(tag, "first fetch address", req_log[n0], exp_first);
        chk(tag, "segments not seen", 64'(exp_q.size()), 64'h0);
        @(negedge clk);
        chk("R11", "done pulse width", {63'h0, done}, 64'h0);
        repeat (4) @(negedge clk);
        chk("R11", "error code held", {58'h0, err_code}, 64'(exp_err));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int n0;
        repeat (3) @(negedge clk);
        // R13 reset state
        chk("R13", "req_valid in reset", {63'h0, req_valid}, 64'h0);
        chk("R13", "seg_valid in reset", {63'h0, seg_valid}, 64'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R13", "done after reset", {63'h0, done}, 64'h0);
        chk("R13", "err_code after reset", {58'h0, err_code}, 64'h0);
        chk("R13", "seg_valid after reset", {63'h0, seg_valid}, 64'h0);

        // R1 R2 R3 R10: plain block, three data entries
        put_ent(64'h1020, 64'hA000, 32'h200, 32'h0);
        put_ent(64'h1030, 64'hB000, 32'h100, 32'h0);
        put_ent(64'h1040, 64'hC000, 32'h080, F_LAST);
        exp_seg(64'hA000, 32'h200, 1'b0, 1'b1);
        exp_seg(64'hB000, 32'h100, 1'b0, 1'b1);
        exp_seg(64'hC000, 32'h080, 1'b0, 1'b0);
        run_walk("R2", 64'h1000, 1'b0, 1'b0, 0, 6, 64'h1020, 1'b0, 1'b0, n0);
        chk("R1", "second beat address", req_log[n0 + 1], 64'h1028);
        chk("R1", "next entry address", req_log[n0 + 2], 64'h1030);

        // R2 packet block
        put_ent(64'h2030, 64'hD000, 32'h40, F_LAST);
        exp_seg(64'hD000, 32'h40, 1'b0, 1'b0);
        run_walk("R2", 64'h2000, 1'b1, 1'b0, 0, 2, 64'h2030, 1'b0, 1'b0, n0);

        // R5 link into a second table, link count ignored
        put_ent(64'h3020, 64'hE000, 32'h10, 32'h0);
        put_ent(64'h3030, 64'h5000, 32'h99, F_LINK);
        put_ent(64'h5000, 64'hF000, 32'h20, F_LAST);
        exp_seg(64'hE000, 32'h10, 1'b0, 1'b1);
        exp_seg(64'hF000, 32'h20, 1'b0, 1'b0);
        run_walk("R5", 64'h3000, 1'b0, 1'b0, 0, 6, 64'h3020, 1'b0, 1'b0, n0);
        chk("R5", "fetch follows link", req_log[n0 + 4], 64'h5000);

        // R4 discard entry
        put_ent(64'h4020, 64'h1234_5678, 32'h300, F_DISC);
        put_ent(64'h4030, 64'h7000, 32'h100, F_LAST);
        exp_seg(64'h0, 32'h300, 1'b1, 1'b1);
        exp_seg(64'h7000, 32'h100, 1'b0, 1'b0);
        run_walk("R4", 64'h4000, 1'b0, 1'b0, 0, 4, 64'h4020, 1'b0, 1'b0, n0);

        // R6 zero-count entry skipped
        put_ent(64'h6020, 64'h8000, 32'h0, 32'h0);
        put_ent(64'h6030, 64'h8100, 32'h10, F_LAST);
        exp_seg(64'h8100, 32'h10, 1'b0, 1'b0);
        run_walk("R6", 64'h6000, 1'b0, 1'b0, 0, 4, 64'h6020, 1'b0, 1'b0, n0);

        // R7 R8 write exhaustion, entry after last not fetched
        put_ent(64'h7020, 64'h9000, 32'h40, F_LAST);
        put_ent(64'h7030, 64'h9999, 32'h10, 32'h0);
        exp_seg(64'h9000, 32'h40, 1'b0, 1'b1);
        run_walk("R8", 64'h7000, 1'b0, 1'b1, 7, 2, 64'h7020, 1'b0, 1'b0, n0);

        // R8 read exhaustion, R11 error cleared on start
        put_ent(64'h7820, 64'h9100, 32'h40, F_LAST);
        put_ent(64'h7830, 64'h9999, 32'h10, 32'h0);
        exp_seg(64'h9100, 32'h40, 1'b0, 1'b1);
        run_walk("R7", 64'h7800, 1'b0, 1'b0, 8, 2, 64'h7820, 1'b1, 1'b0, n0);

        // R9 misaligned first table
        run_walk("R9", 64'h8004, 1'b0, 1'b0, 16, 0, 64'h0, 1'b0, 1'b0, n0);

        // R9 misaligned link target
        put_ent(64'h9020, 64'hA004, 32'h0, F_LINK);
        run_walk("R9", 64'h9000, 1'b0, 1'b0, 16, 2, 64'h9020, 1'b0, 1'b0, n0);

        // R10 device finishes early
        put_ent(64'hA820, 64'h3000, 32'h10, 32'h0);
        put_ent(64'hA830, 64'h3100, 32'h10, 32'h0);
        put_ent(64'hA840, 64'h3200, 32'h10, F_LAST);
        exp_seg(64'h3000, 32'h10, 1'b0, 1'b0);
        run_walk("R10", 64'hA800, 1'b0, 1'b0, 0, 2, 64'hA820, 1'b1, 1'b0, n0);

        // R12 start while busy ignored
        put_ent(64'hB820, 64'h1100, 32'h10, 32'h0);
        put_ent(64'hB830, 64'h1200, 32'h10, F_LAST);
        exp_seg(64'h1100, 32'h10, 1'b0, 1'b1);
        exp_seg(64'h1200, 32'h10, 1'b0, 1'b0);
        run_walk("R12", 64'hB800, 1'b0, 1'b0, 0, 4, 64'hB820, 1'b0, 1'b1, n0);

        // R7 last entry that is a link is not followed
        put_ent(64'hC820, 64'h5000, 32'h0, F_LINK | F_LAST);
        run_walk("R7", 64'hC800, 1'b0, 1'b0, 8, 2, 64'hC820, 1'b0, 1'b0, n0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule